// File: doc/BRIEF.md
# Indexed Operand Address Generator

This block turns a fetched 32-bit instruction word into the operand that the instruction acts on. It splits the word into its fields and widens the 17-bit embedded constant to full width by sign extension. It then adds that constant to one of eight index registers. In immediate mode the sum is the operand. In the three memory modes the sum is an address, and the block reads one word from memory at that address. Two of the memory modes also update the index register: one increments it after the access, the other decrements it before the address is formed.

The register file and the memory are outside the block. The block reads the register file combinationally in the cycle of the start strobe. It sends any index update back through a write port, which is enabled only in the cycle of the done pulse. Register code 4 is a constant zero. Register code 7 is the program counter, which holds the address of the word after the current instruction. Post-increment through it therefore fetches an inline full-width constant and steps execution past that constant.

Top module: `opnd_agen`

## Requirements
- R1: Field layout of `instr_i`: opcode in bits 31:26, mode in bits 25:24, an unused 4-bit field in bits 23:20, register select in bits 19:17, constant in bits 16:0. `opcode_o` presents bits 31:26 of the instruction captured at start.
- R2: The constant is sign-extended from bit 16. 17'h0FFFF adds 65535 and 17'h10000 adds -65536.
- R3: Register select 4 reads as zero whatever the register file returns. Modes 1, 2 and 3 through it all give address = extended constant. `rf_we_o` is never raised with `rf_waddr_o` = 4.
- R4: Mode 0 (immediate): `ea_o` = `operand_o` = index + constant. No memory request is made. `done_o` is high in the cycle right after the start edge.
- R5: Mode 1 (absolute): `mem_req_o` rises in the cycle after start and holds, with `mem_addr_o` = index + constant stable, until `mem_ack_i` is sampled high. `operand_o` is then the `mem_rdata_i` of that cycle. No write-back is made.
- R6: Mode 2 (post-increment): the address is formed as in R5. In the done cycle the selected register receives its old value + 1.
- R7: Mode 3 (pre-decrement): address = (index - 1) + constant. In the done cycle the selected register receives index - 1.
- R8: Mode 2 with register 7 and constant 0 returns the word at the program counter, and writes the program counter + 1 back to register 7.
- R9: `done_o` is a single-cycle pulse, high in the cycle after the ack edge for memory modes. `rf_we_o` is high only while `done_o` is high.
- R10: `start_i` is ignored while an operation is in flight (request pending or done cycle). A start in that time neither changes the result nor launches a second operation.
- R11: During and right after reset, `done_o`, `mem_req_o` and `rf_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin operand generation for `instr_i` |
| instr_i | input | 32 | Instruction word |
| rf_raddr_o | output | 3 | Register file read select |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Index write-back enable |
| rf_waddr_o | output | 3 | Index write-back select |
| rf_wdata_o | output | 32 | Index write-back value |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory word address |
| mem_ack_i | input | 1 | Memory read acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| ea_o | output | 32 | Effective address / immediate sum |
| operand_o | output | 32 | Resolved operand |
| opcode_o | output | 6 | Captured opcode field |
| done_o | output | 1 | Operand ready pulse |

## Verification
The bench loads the zero register's register file slot with a non-zero value. A design that indexed through it literally would form wrong addresses, and a design that let the zero register decrement or write back would show up at the write port. Constants at both ends of the 17-bit range catch extension from the wrong bit or zero-filling. Chained post-increment and pre-decrement on the same register catch a decrement applied after the access instead of before it, and a write-back of the wrong value. Varied ack latencies and a start pulse injected mid-flight expose a request dropped early, a moving address, a done in the wrong cycle, and a second operation launched while busy.

// File: rtl/opnd_agen_pkg.sv
package opnd_agen_pkg;
  localparam int DW       = 32;
  localparam int IMMW     = 17;
  localparam int RSW      = 3;
  localparam int FNW      = 4;
  localparam int MODEW    = 2;
  localparam int OPCW     = 6;
  localparam int RS_LSB   = IMMW;
  localparam int FN_LSB   = RS_LSB + RSW;
  localparam int MODE_LSB = FN_LSB + FNW;
  localparam int OPC_LSB  = MODE_LSB + MODEW;

  localparam logic [RSW-1:0] RS_ZERO = 3'd4;
  localparam logic [RSW-1:0] RS_PC   = 3'd7;

  typedef enum logic [MODEW-1:0] {
    AM_IMM  = 2'd0,
    AM_ABS  = 2'd1,
    AM_POST = 2'd2,
    AM_PRE  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_FIN} state_e;

  typedef struct packed {
    logic [OPCW-1:0] opc;
    amode_e          mode;
    logic [RSW-1:0]  rsel;
    logic [DW-1:0]   ext;
  } dec_t;
endpackage

// File: rtl/opnd_field_split.sv
module opnd_field_split
  import opnd_agen_pkg::*;
(
  input  logic [DW-1:0] instr_i,
  output dec_t          dec_o
);
  logic [FNW-1:0] unused_fn;
  assign unused_fn = instr_i[FN_LSB +: FNW];

  assign dec_o.opc  = instr_i[OPC_LSB +: OPCW];
  assign dec_o.mode = amode_e'(instr_i[MODE_LSB +: MODEW]);
  assign dec_o.rsel = instr_i[RS_LSB +: RSW];
  assign dec_o.ext  = {{(DW-IMMW){instr_i[IMMW-1]}}, instr_i[IMMW-1:0]};
endmodule

// File: rtl/opnd_index_step.sv
module opnd_index_step
  import opnd_agen_pkg::*;
(
  input  amode_e         mode_i,
  input  logic [RSW-1:0] rsel_i,
  input  logic [DW-1:0]  idx_i,
  output logic [DW-1:0]  base_o,
  output logic [DW-1:0]  wb_val_o,
  output logic           wb_en_o
);
  logic          is_zero;
  logic [DW-1:0] idx;

  assign is_zero = (rsel_i == RS_ZERO);
  assign idx     = is_zero ? '0 : idx_i;

  // zero register never steps, so its three memory modes coincide
  always_comb begin
    base_o   = idx;
    wb_val_o = idx - DW'(1);
    wb_en_o  = 1'b0;
    unique case (mode_i)
      AM_POST: begin
        wb_val_o = idx + DW'(1);
        wb_en_o  = !is_zero;
      end
      AM_PRE: begin
        if (!is_zero) base_o = idx - DW'(1);
        wb_en_o = !is_zero;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opnd_agen.sv
module opnd_agen
  import opnd_agen_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [DW-1:0]   instr_i,
  output logic [RSW-1:0]  rf_raddr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [RSW-1:0]  rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic            mem_req_o,
  output logic [DW-1:0]   mem_addr_o,
  input  logic            mem_ack_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [DW-1:0]   ea_o,
  output logic [DW-1:0]   operand_o,
  output logic [OPCW-1:0] opcode_o,
  output logic            done_o
);
  dec_t          dec;
  logic [DW-1:0] base, wb_val, ea_d;
  logic          wb_en;

  state_e          st_q;
  logic [OPCW-1:0] opc_q;
  logic [DW-1:0]   ea_q, opnd_q, wb_val_q;
  logic [RSW-1:0]  wb_addr_q;
  logic            wb_en_q;

  opnd_field_split u_split (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  opnd_index_step u_step (
    .mode_i   (dec.mode),
    .rsel_i   (dec.rsel),
    .idx_i    (rf_rdata_i),
    .base_o   (base),
    .wb_val_o (wb_val),
    .wb_en_o  (wb_en)
  );

  assign rf_raddr_o = dec.rsel;
  assign ea_d       = base + dec.ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      opc_q     <= '0;
      ea_q      <= '0;
      opnd_q    <= '0;
      wb_val_q  <= '0;
      wb_addr_q <= '0;
      wb_en_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          opc_q     <= dec.opc;
          ea_q      <= ea_d;
          wb_val_q  <= wb_val;
          wb_addr_q <= dec.rsel;
          wb_en_q   <= wb_en;
          if (dec.mode == AM_IMM) begin
            opnd_q <= ea_d;
            st_q   <= ST_FIN;
          end else begin
            st_q <= ST_MEM;
          end
        end
        ST_MEM: if (mem_ack_i) begin
          opnd_q <= mem_rdata_i;
          st_q   <= ST_FIN;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == ST_MEM);
  assign mem_addr_o = ea_q;
  assign done_o     = (st_q == ST_FIN);
  assign rf_we_o    = done_o && wb_en_q;
  assign rf_waddr_o = wb_addr_q;
  assign rf_wdata_o = wb_val_q;
  assign ea_o       = ea_q;
  assign operand_o  = opnd_q;
  assign opcode_o   = opc_q;
endmodule

// File: rtl/opnd_agen_chk.sv
module opnd_agen_chk
  import opnd_agen_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [DW-1:0]  instr_i,
  input logic           mem_req_o,
  input logic [DW-1:0]  mem_addr_o,
  input logic           mem_ack_i,
  input logic           done_o,
  input logic           rf_we_o,
  input logic [RSW-1:0] rf_waddr_o
);
  logic idle;
  assign idle = !mem_req_o && !done_o;

  p_we_in_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> done_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ack_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> (done_o && !mem_req_o));

  p_no_zero_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_waddr_o != RS_ZERO));

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_imm_fast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && instr_i[MODE_LSB +: MODEW] == 2'd0) |=> (done_o && !mem_req_o));

  p_mem_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && instr_i[MODE_LSB +: MODEW] != 2'd0) |=> (mem_req_o && !done_o));

  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (!done_o && !mem_req_o));
endmodule

bind opnd_agen opnd_agen_chk u_chk (.*);

// File: tb/opnd_agen_tb.sv
module opnd_agen_tb;
  import opnd_agen_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [DW-1:0]   instr_i = '0;
  logic [RSW-1:0]  rf_raddr_o;
  logic [DW-1:0]   rf_rdata_i;
  logic            rf_we_o;
  logic [RSW-1:0]  rf_waddr_o;
  logic [DW-1:0]   rf_wdata_o;
  logic            mem_req_o;
  logic [DW-1:0]   mem_addr_o;
  logic            mem_ack_i = 1'b0;
  logic [DW-1:0]   mem_rdata_i = '0;
  logic [DW-1:0]   ea_o, operand_o;
  logic [OPCW-1:0] opcode_o;
  logic            done_o;

  logic [DW-1:0] rf_mdl [8];
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign rf_rdata_i = rf_mdl[rf_raddr_o];

  opnd_agen u_dut (.*);

  function automatic logic [DW-1:0] mem_val(input logic [DW-1:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [5:0]  opc;
    logic [1:0]  mode;
    logic [2:0]  rs;
    logic [16:0] imm;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{6'h10, 2'd0, 3'd2, 17'h00005,  4'd0}, // R4 x+5
    '{6'h05, 2'd0, 3'd4, 17'h10000,  4'd0}, // R2 R3 z-65536
    '{6'h3F, 2'd0, 3'd0, 17'h0FFFF,  4'd0}, // R2 a+65535
    '{6'h11, 2'd1, 3'd1, 17'h1FFFF,  4'd0}, // R5 b-1
    '{6'h20, 2'd2, 3'd6, 17'h00000,  4'd2}, // R6 s post
    '{6'h21, 2'd3, 3'd6, 17'h00000,  4'd1}, // R7 s pre
    '{6'h17, 2'd2, 3'd7, 17'h00000,  4'd0}, // R8 inline word
    '{6'h2A, 2'd3, 3'd4, 17'h00003,  4'd1}, // R3 z pre
    '{6'h01, 2'd2, 3'd5, 17'h00002,  4'd3}, // R6 u post wrap region
    '{6'h02, 2'd1, 3'd7, 17'h1FFFE,  4'd2}  // R5 pc-2
  };

  task automatic run_op(input vec_t v, input bit poke);
    logic [DW-1:0] ins, ext, idx, base, ea_x, op_x, wb_x;
    bit            isz, wb_on;
    ins   = {v.opc, v.mode, 4'hA, v.rs, v.imm};
    ext   = {{15{v.imm[16]}}, v.imm};
    isz   = (v.rs == 3'd4);
    idx   = isz ? '0 : rf_mdl[v.rs];
    base  = (v.mode == 2'd3 && !isz) ? idx - 1 : idx;
    ea_x  = base + ext;
    op_x  = (v.mode == 2'd0) ? ea_x : mem_val(ea_x);
    wb_on = (v.mode >= 2'd2) && !isz;
    wb_x  = (v.mode == 2'd2) ? idx + 1 : idx - 1;

    @(negedge clk_i);
    start_i = 1'b1;
    instr_i = ins;
    @(negedge clk_i);
    start_i = 1'b0;
    instr_i = '1;
    if (v.mode == 2'd0) begin
      chk(!mem_req_o, "R4 no request", 32'(mem_req_o), 0);
    end else begin
      chk(mem_req_o && !done_o, "R5 request after start", 32'(mem_req_o), 1);
      chk(mem_addr_o == ea_x, "R5/R7 address", mem_addr_o, ea_x);
      for (int i = 0; i < int'(v.lat); i++) begin
        if (poke && i == 0) begin
          start_i = 1'b1;
          instr_i = {6'h33, 2'd0, 4'h0, 3'd0, 17'h00001};
        end
        @(negedge clk_i);
        start_i = 1'b0;
        instr_i = '1;
        chk(mem_req_o && !done_o && mem_addr_o == ea_x, "R5 request held", mem_addr_o, ea_x);
      end
      mem_ack_i   = 1'b1;
      mem_rdata_i = mem_val(mem_addr_o);
      @(negedge clk_i);
      mem_ack_i   = 1'b0;
      mem_rdata_i = '0;
    end
    chk(done_o, "R9 done timing", 32'(done_o), 1);
    chk(ea_o == ea_x, "R2/R4 effective address", ea_o, ea_x);
    chk(operand_o == op_x, "R4/R5 operand", operand_o, op_x);
    chk(opcode_o == v.opc, "R1 opcode", 32'(opcode_o), 32'(v.opc));
    chk(rf_we_o == wb_on, "R3/R6/R7 write enable", 32'(rf_we_o), 32'(wb_on));
    if (wb_on) begin
      chk(rf_waddr_o == v.rs, "R6/R7 write select", 32'(rf_waddr_o), 32'(v.rs));
      chk(rf_wdata_o == wb_x, "R6/R7/R8 write value", rf_wdata_o, wb_x);
    end
    if (poke) begin
      start_i = 1'b1;
      instr_i = {6'h33, 2'd1, 4'h0, 3'd0, 17'h00001};
    end
    @(posedge clk_i);
    if (rf_we_o) rf_mdl[rf_waddr_o] = rf_wdata_o;
    @(negedge clk_i);
    start_i = 1'b0;
    instr_i = '0;
    chk(!done_o && !mem_req_o, "R9/R10 single pulse, no relaunch", 32'(done_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rf_mdl[0] = 32'd100;
    rf_mdl[1] = 32'h0000_1000;
    rf_mdl[2] = 32'h0000_2000;
    rf_mdl[3] = 32'd5;
    rf_mdl[4] = 32'hDEAD_BEEF;
    rf_mdl[5] = 32'hFFFF_FFF0;
    rf_mdl[6] = 32'h0000_0300;
    rf_mdl[7] = 32'h0000_0400;

    start_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!done_o && !mem_req_o && !rf_we_o, "R11 in reset", 32'(done_o), 0);
    rst_ni  = 1'b1;
    start_i = 1'b0;
    @(negedge clk_i);
    chk(!done_o && !mem_req_o && !rf_we_o, "R11 after reset", 32'(mem_req_o), 0);

    for (int k = 0; k < NV; k++) run_op(VECS[k], 1'b0);

    // R10: starts during a pending request and during done
    run_op('{6'h0C, 2'd1, 3'd2, 17'h00000, 4'd3}, 1'b1);
    // R8 again: pc advanced by the earlier inline fetch
    run_op('{6'h17, 2'd2, 3'd7, 17'h00000, 4'd0}, 1'b0);
    chk(rf_mdl[7] == 32'h0000_0402, "R8 pc past inline words", rf_mdl[7], 32'h0000_0402);
    chk(rf_mdl[6] == 32'h0000_0300, "R6/R7 post then pre restores", rf_mdl[6], 32'h0000_0300);
    chk(rf_mdl[4] == 32'hDEAD_BEEF, "R3 zero slot untouched", rf_mdl[4], 32'hDEAD_BEEF);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule